// File: doc/BRIEF.md
# Ethernet MAC Management Registers with Duplex Consistency Monitor

This block is the control-path register bank of an Ethernet MAC. It keeps the station address, group hash table and control words that the rest of the MAC reads. Software reaches it over a simple 32-bit register bus that carries byte addresses; the block ignores the two low address bits and decodes whole words. One management-control word lets software drive the PHY management lines (clock, data, data enable) directly, so a driver can run any MDIO transaction in software. A status word shows the live level of the incoming MDIO line.

When software is not driving the management bus, an internal sequencer polls PHY status register 18 with standard clause-22 read frames. Bit 11 of the returned value is the duplex the PHY has resolved. A monitor compares that bit with the duplex the MAC is configured for. It repeats the comparison after each software change of the management clock bit, after each write of the receive-configuration word, and after each completed poll. The result is a mismatch flag and a one-cycle event whenever the flag changes. The monitor updates the flag only while its enable bit is set in the general-control word.

Top module: `mac_mgmt_regs`

## Requirements
- R1: Reset clears every register to zero, clears the mismatch flag, and drives MDC, MDIO data and MDIO enable low.
- R2: Register words are selected by bus_addr[5:2]. Words 0 to 10 (station 0 low/high at 0/1, station 1 low/high at 2/3, group table low/high at 4/5, general control 6, receive configuration 7, transmit configuration 8, error clear 9, management control 10) return on read exactly what was last written to them. Read data appears on bus_rdata in the cycle after bus_rd.
- R3: A read of word 11 returns the level of mdio_i in bit 0 and zeros in the other bits. Writes to word 11 have no effect.
- R4: While no poll is running, mdc follows management-control bit 2, mdio_oe follows bit 1 and mdio_o follows bit 0, each two clocks after the write.
- R5: The poll frame is PRE_LEN one bits, then start 01, read opcode 10, the 5-bit PHY address MSB first, register 18 (10010) MSB first, all driven with mdio_oe high. mdio_oe is low for the turnaround and the 16 data bits, which are sampled MSB first while mdc is high.
- R6: A write to management control aborts a running poll at once. No poll starts while management-control bit 1 is set.
- R7: The mismatch flag becomes (receive-configuration bit 7 XOR bit 11 of the last polled PHY register 18). It is re-evaluated after any write to receive configuration, after any write that changes management-control bit 2, and after each completed poll.
- R8: While general-control bit 0 is clear, the mismatch flag holds its value through all triggers. Setting bit 0 alone does not re-evaluate it.
- R9: mismatch_evt is high for exactly one cycle each time the mismatch flag changes, and never otherwise.
- R10: Reads of word addresses 12 to 15 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address; bits 5:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data line level |
| duplex_mismatch | output | 1 | MAC and PHY duplex disagree |
| mismatch_evt | output | 1 | One-cycle pulse on each change of the mismatch flag |

## Verification
The bench writes random data to the plain registers and reads it back. This catches address decode that aliases words or clobbers a neighbour. A bench PHY model records every command bit of a poll frame and returns a chosen register 18 value. A wrong opcode, register number or bit order would show up in the recorded command bits or in the wrong duplex being captured. Directed sequences check each trigger (receive-config write, software MDC toggle, poll completion) with the enable bit both clear and set. A monitor that updated without a trigger or with the enable bit clear would move the flag early or produce extra events. Software writes are also issued in the middle of a frame and while software holds the bus. A sequencer that ignored the abort or started while software held the bus would leave mdc toggling against the software value.

// File: rtl/mac_mgmt_pkg.sv
package mac_mgmt_pkg;
  // word indices of the register map
  localparam int RA_STATION0_LO = 0;
  localparam int RA_STATION0_HI = 1;
  localparam int RA_STATION1_LO = 2;
  localparam int RA_STATION1_HI = 3;
  localparam int RA_GROUP_LO    = 4;
  localparam int RA_GROUP_HI    = 5;
  localparam int RA_GENERAL     = 6;
  localparam int RA_RXCFG       = 7;
  localparam int RA_TXCFG       = 8;
  localparam int RA_ERRCLR      = 9;
  localparam int RA_MGMT        = 10;
  localparam int RA_STATUS      = 11;
  localparam int REG_WORDS      = 12;
  localparam int STORED_WORDS   = REG_WORDS - 1;

  // control bit positions
  localparam int MGMT_DATA_BIT  = 0;
  localparam int MGMT_OE_BIT    = 1;
  localparam int MGMT_MDC_BIT   = 2;
  localparam int GEN_MON_EN_BIT = 0;
  localparam int RX_FULLDUP_BIT = 7;

  // PHY side
  localparam int PHY_STAT_REG   = 18;
  localparam int PHY_DUPLEX_BIT = 11;
  localparam int MDIO_DATA_BITS = 16;
endpackage

// File: rtl/mac_reg_file.sv
module mac_reg_file
  import mac_mgmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdio_level,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mgmt_q,
  output logic [DATA_W-1:0] rxcfg_q,
  output logic [DATA_W-1:0] gen_q,
  output logic              mgmt_wr,
  output logic              mdc_change,
  output logic              rxcfg_wr
);
  localparam int WORD_W = ADDR_W - 2;

  logic [DATA_W-1:0] regs [STORED_WORDS];
  logic [WORD_W-1:0] word;
  logic              in_store;
  logic              is_status;

  assign word      = addr[ADDR_W-1:2];
  assign in_store  = int'(word) < STORED_WORDS;
  assign is_status = int'(word) == RA_STATUS;

  assign mgmt_q  = regs[RA_MGMT];
  assign rxcfg_q = regs[RA_RXCFG];
  assign gen_q   = regs[RA_GENERAL];

  assign mgmt_wr    = wr_en && int'(word) == RA_MGMT;
  assign mdc_change = mgmt_wr && (wdata[MGMT_MDC_BIT] != regs[RA_MGMT][MGMT_MDC_BIT]);
  assign rxcfg_wr   = wr_en && int'(word) == RA_RXCFG;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STORED_WORDS; i++) regs[i] <= '0;
    end else if (wr_en && in_store) begin
      regs[int'(word)] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (is_status)     rdata <= {{(DATA_W-1){1'b0}}, mdio_level};
      else if (in_store) rdata <= regs[int'(word)];
      else               rdata <= '0;
    end
  end

  // R2: a write to a stored word is visible in that word on the next cycle
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(word) == RA_TXCFG) |=> (regs[RA_TXCFG] == $past(wdata)));
endmodule

// File: rtl/mdio_poll_seq.sv
module mdio_poll_seq
  import mac_mgmt_pkg::*;
#(
  parameter int PRE_LEN  = 32,
  parameter int HALF_CYC = 2,
  parameter int GAP_CYC  = 64,
  parameter int PHY_ADDR = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hold,
  input  logic                      abort,
  input  logic                      mdio_i,
  output logic                      busy,
  output logic                      seq_mdc,
  output logic                      seq_o,
  output logic                      seq_oe,
  output logic                      done,
  output logic [MDIO_DATA_BITS-1:0] rd_data
);
  localparam int CMD_BITS   = 14;
  localparam int CMD_END    = PRE_LEN + CMD_BITS;
  localparam int DATA_START = CMD_END + 2;
  localparam int FRAME_BITS = DATA_START + MDIO_DATA_BITS;
  localparam int BIT_W      = $clog2(FRAME_BITS + 1);
  localparam int DIV_W      = $clog2(HALF_CYC + 1);
  localparam int GAP_W      = $clog2(GAP_CYC + 1);
  localparam logic [CMD_BITS-1:0] CMD =
    {2'b01, 2'b10, 5'(PHY_ADDR), 5'(PHY_STAT_REG)};

  logic [BIT_W-1:0]          bitn;
  logic [DIV_W-1:0]          div;
  logic [GAP_W-1:0]          gap;
  logic                      high;
  logic [MDIO_DATA_BITS-1:0] shreg;
  logic [BIT_W-1:0]          next_bit;

  assign next_bit = bitn + BIT_W'(1);

  // returns {data, enable} for frame bit idx
  function automatic logic [1:0] bit_drive(input logic [BIT_W-1:0] idx);
    int i;
    i = int'(idx);
    if (i < PRE_LEN)      return 2'b11;
    else if (i < CMD_END) return {CMD[CMD_BITS-1-(i-PRE_LEN)], 1'b1};
    else                  return 2'b00;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; seq_mdc <= 1'b0; seq_o <= 1'b0; seq_oe <= 1'b0;
      done <= 1'b0; rd_data <= '0; shreg <= '0;
      bitn <= '0; div <= '0; gap <= '0; high <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0; seq_mdc <= 1'b0; seq_o <= 1'b0; seq_oe <= 1'b0;
        gap <= '0;
      end else if (!busy) begin
        if (hold) begin
          gap <= '0;
        end else if (gap == GAP_W'(GAP_CYC - 1)) begin
          busy <= 1'b1; bitn <= '0; div <= '0; high <= 1'b0;
          seq_mdc <= 1'b0; {seq_o, seq_oe} <= 2'b11; gap <= '0;
        end else begin
          gap <= gap + GAP_W'(1);
        end
      end else if (div != DIV_W'(HALF_CYC - 1)) begin
        div <= div + DIV_W'(1);
      end else begin
        div <= '0;
        if (!high) begin
          high <= 1'b1; seq_mdc <= 1'b1;
        end else begin
          high <= 1'b0; seq_mdc <= 1'b0;
          if (bitn >= BIT_W'(DATA_START))
            shreg <= {shreg[MDIO_DATA_BITS-2:0], mdio_i};
          if (bitn == BIT_W'(FRAME_BITS - 1)) begin
            busy <= 1'b0; done <= 1'b1; seq_o <= 1'b0; seq_oe <= 1'b0;
            rd_data <= {shreg[MDIO_DATA_BITS-2:0], mdio_i};
          end else begin
            bitn <= next_bit;
            {seq_o, seq_oe} <= bit_drive(next_bit);
          end
        end
      end
    end
  end

  // R6: an abort request leaves the sequencer idle on the next cycle
  assert_abort_idles_R6: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy);
  // R5: the line is released during turnaround and data bits
  assert_released_in_data_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && bitn >= BIT_W'(CMD_END)) |-> !seq_oe);
  // R5: the management clock only toggles while a frame is running
  assert_mdc_only_when_busy_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !seq_mdc);
endmodule

// File: rtl/duplex_monitor.sv
module duplex_monitor (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic enable,
  input  logic mac_full,
  input  logic phy_full,
  output logic flag,
  output logic evt
);
  logic pend;
  logic differ;

  assign differ = mac_full ^ phy_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0; flag <= 1'b0; evt <= 1'b0;
    end else begin
      pend <= trig;
      if (pend && enable) begin
        flag <= differ;
        evt  <= differ != flag;
      end else begin
        evt  <= 1'b0;
      end
    end
  end

  // R8: with the monitor disabled the flag holds
  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(flag));
  // R9: an event accompanies every change and only a change
  assert_evt_marks_change_R9: assert property (@(posedge clk) disable iff (rst)
    evt |-> (flag != $past(flag)));
  assert_no_silent_change_R9: assert property (@(posedge clk) disable iff (rst)
    !evt |-> $stable(flag));
  // R7: without a pending trigger the flag cannot move
  assert_needs_trigger_R7: assert property (@(posedge clk) disable iff (rst)
    !pend |=> $stable(flag));
endmodule

// File: rtl/mac_mgmt_regs.sv
module mac_mgmt_regs
  import mac_mgmt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int PRE_LEN  = 32,
  parameter int MDC_HALF = 2,
  parameter int POLL_GAP = 64,
  parameter int PHY_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              duplex_mismatch,
  output logic              mismatch_evt
);
  logic [DATA_W-1:0]         mgmt_q, rxcfg_q, gen_q;
  logic                      mgmt_wr, mdc_change, rxcfg_wr;
  logic                      seq_busy, seq_mdc, seq_o, seq_oe, seq_done;
  logic [MDIO_DATA_BITS-1:0] seq_data;
  logic                      phy_full, fresh;

  mac_reg_file #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .mdio_level(mdio_i), .rdata(bus_rdata),
    .mgmt_q(mgmt_q), .rxcfg_q(rxcfg_q), .gen_q(gen_q),
    .mgmt_wr(mgmt_wr), .mdc_change(mdc_change), .rxcfg_wr(rxcfg_wr)
  );

  mdio_poll_seq #(.PRE_LEN(PRE_LEN), .HALF_CYC(MDC_HALF),
                  .GAP_CYC(POLL_GAP), .PHY_ADDR(PHY_ADDR)) u_seq (
    .clk(clk), .rst(rst), .hold(mgmt_q[MGMT_OE_BIT]), .abort(mgmt_wr),
    .mdio_i(mdio_i), .busy(seq_busy), .seq_mdc(seq_mdc), .seq_o(seq_o),
    .seq_oe(seq_oe), .done(seq_done), .rd_data(seq_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_full <= 1'b0; fresh <= 1'b0;
      mdc <= 1'b0; mdio_o <= 1'b0; mdio_oe <= 1'b0;
    end else begin
      fresh <= seq_done;
      if (seq_done) phy_full <= seq_data[PHY_DUPLEX_BIT];
      if (seq_busy) begin
        mdc <= seq_mdc; mdio_o <= seq_o; mdio_oe <= seq_oe;
      end else begin
        mdc     <= mgmt_q[MGMT_MDC_BIT];
        mdio_o  <= mgmt_q[MGMT_DATA_BIT];
        mdio_oe <= mgmt_q[MGMT_OE_BIT];
      end
    end
  end

  duplex_monitor u_mon (
    .clk(clk), .rst(rst), .trig(rxcfg_wr | mdc_change | fresh),
    .enable(gen_q[GEN_MON_EN_BIT]), .mac_full(rxcfg_q[RX_FULLDUP_BIT]),
    .phy_full(phy_full), .flag(duplex_mismatch), .evt(mismatch_evt)
  );

  // R6: software ownership of the bus keeps the sequencer from starting
  assert_no_poll_when_owned_R6: assert property (@(posedge clk) disable iff (rst)
    (mgmt_q[MGMT_OE_BIT] && !seq_busy) |=> !seq_busy);
  // R4: the sample clock needs at least two cycles per half period
  assert_half_period_R4: assert property (@(posedge clk) disable iff (rst)
    MDC_HALF >= 2);
endmodule

// File: tb/mac_mgmt_regs_test.sv
module mac_mgmt_regs_test;
  localparam int PRE    = 32;
  localparam int PADDR  = 1;
  localparam int CSTART = PRE;
  localparam int DSTART = PRE + 16;
  localparam int FRAME  = PRE + 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        duplex_mismatch, mismatch_evt;

  int n_chk = 0, n_bad = 0, evt_cnt = 0;
  bit finished = 0;

  // bench PHY model
  logic [15:0]      phy18 = 16'h0000;
  logic             phy_bit = 1'b1;
  logic             force_line = 1'b0, line_level = 1'b0;
  int               edge_cnt = 0, frames_seen = 0;
  logic [FRAME-1:0] seen_o = '0;
  bit               oe_bad = 0;

  assign mdio_i = force_line ? line_level : phy_bit;

  always #5 clk = ~clk;

  mac_mgmt_regs uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .duplex_mismatch(duplex_mismatch), .mismatch_evt(mismatch_evt)
  );

  always @(posedge mdio_oe) edge_cnt = 0;

  always @(posedge mdc) begin
    if (edge_cnt < FRAME) seen_o[edge_cnt] = mdio_o;
    if (edge_cnt >= DSTART && edge_cnt < FRAME) begin
      if (mdio_oe) oe_bad = 1;
      phy_bit = phy18[15-(edge_cnt-DSTART)];
    end else begin
      phy_bit = 1'b1;
    end
    edge_cnt++;
    if (edge_cnt == FRAME) frames_seen++;
  end

  always @(negedge clk) if (!rst && mismatch_evt) evt_cnt++;

  function automatic logic [13:0] exp_cmd();
    return {2'b01, 2'b10, 5'(PADDR), 5'd18};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'(w << 2); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int w, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 6'((w << 2) | 1);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_polls(input int n);
    int start;
    start = frames_seen;
    while (frames_seen < start + n) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] model [10];
    int plain [8] = '{0, 1, 2, 3, 4, 5, 8, 9};
    int ev;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 10; i++) model[i] = '0;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 mdc", {31'b0, mdc}, 0);
    chk("R1 mdio_oe", {31'b0, mdio_oe}, 0);
    chk("R1 mdio_o", {31'b0, mdio_o}, 0);
    chk("R1 flag", {31'b0, duplex_mismatch}, 0);
    for (int w = 0; w < 11; w++) begin
      rd(w, v);
      chk("R1 reg clear", v, 0);
    end

    // R10 words past the map
    wr(13, 32'hDEADBEEF);
    rd(13, v); chk("R10 word13", v, 0);
    rd(12, v); chk("R10 word12", v, 0);
    for (int w = 0; w < 11; w++) begin
      rd(w, v);
      chk("R10 no alias", v, 0);
    end

    // R2 random plain register traffic
    for (int i = 0; i < 40; i++) begin
      int w, r;
      logic [31:0] d;
      w = plain[$urandom % 8];
      d = $urandom;
      wr(w, d);
      model[w] = d;
      r = plain[$urandom % 8];
      rd(r, v);
      chk("R2 readback", v, model[r]);
    end

    // R3 status word
    force_line = 1'b1; line_level = 1'b1;
    rd(11, v); chk("R3 line high", v, 1);
    line_level = 1'b0;
    rd(11, v); chk("R3 line low", v, 0);
    wr(11, 32'hFFFF_FFFF);
    rd(11, v); chk("R3 write ignored", v, 0);
    force_line = 1'b0;

    // R5 poll frame shape; R8 flag holds with monitor disabled
    phy18 = 16'h0800;
    wait_polls(2);
    for (int j = 0; j < PRE; j++)
      if (seen_o[j] !== 1'b1) chk("R5 preamble", {31'b0, seen_o[j]}, 1);
    chk("R5 preamble seen", {31'b0, &seen_o[PRE-1:0]}, 1);
    chk("R5 command", {18'b0, seen_o[CSTART+13:CSTART]},
        {18'b0, {<<{exp_cmd()}}});
    chk("R5 released in data", {31'b0, oe_bad}, 0);
    chk("R8 disabled hold", {31'b0, duplex_mismatch}, 0);
    chk("R9 no event", evt_cnt, 0);

    // take the bus (no clock change) so polls stop
    wr(10, 32'h2);
    wr(6, 32'h1);
    repeat (2) @(negedge clk);
    chk("R8 enable alone", {31'b0, duplex_mismatch}, 0);
    // R7 receive-config trigger
    wr(7, 32'h0);
    repeat (2) @(negedge clk);
    chk("R7 rx write mismatch", {31'b0, duplex_mismatch}, 1);
    chk("R9 one event", evt_cnt, 1);
    wr(7, 32'h80);
    repeat (2) @(negedge clk);
    chk("R7 rx write match", {31'b0, duplex_mismatch}, 0);
    chk("R9 two events", evt_cnt, 2);
    // R8 disabled: trigger ignored
    wr(6, 32'h0);
    wr(7, 32'h0);
    repeat (2) @(negedge clk);
    chk("R8 trigger while disabled", {31'b0, duplex_mismatch}, 0);
    wr(6, 32'h1);
    repeat (2) @(negedge clk);
    chk("R8 enable no trigger", {31'b0, duplex_mismatch}, 0);
    // R7 software MDC change trigger, R4 pins
    wr(10, 32'h6);
    repeat (2) @(negedge clk);
    chk("R7 mdc toggle", {31'b0, duplex_mismatch}, 1);
    chk("R9 three events", evt_cnt, 3);
    chk("R4 mdc", {31'b0, mdc}, 1);
    chk("R4 oe", {31'b0, mdio_oe}, 1);
    chk("R4 data", {31'b0, mdio_o}, 0);
    // R6 no poll while software holds the bus
    ev = frames_seen;
    repeat (400) @(negedge clk);
    chk("R6 held no frames", frames_seen, ev);
    chk("R6 held mdc", {31'b0, mdc}, 1);
    wr(10, 32'h3);
    repeat (2) @(negedge clk);
    chk("R4 mdc low", {31'b0, mdc}, 0);
    chk("R4 data high", {31'b0, mdio_o}, 1);
    chk("R9 no event on same result", evt_cnt, 3);

    // R7 poll refresh
    wr(10, 32'h0);
    phy18 = 16'h0000;
    wait_polls(2);
    chk("R7 poll refresh", {31'b0, duplex_mismatch}, 0);
    chk("R9 four events", evt_cnt, 4);

    // R6 abort mid-frame
    while (mdio_oe !== 1'b1) @(negedge clk);
    repeat (20) @(negedge clk);
    wr(10, 32'h6);
    repeat (2) @(negedge clk);
    chk("R6 abort mdc", {31'b0, mdc}, 1);
    chk("R6 abort oe", {31'b0, mdio_oe}, 1);
    chk("R6 abort data", {31'b0, mdio_o}, 0);
    repeat (20) @(negedge clk);
    chk("R6 stays software", {31'b0, mdc}, 1);
    chk("R9 no spurious event", evt_cnt, 4);

    finished = 1;
    summary();
    $finish;
  end
endmodule